// File: doc/BRIEF.md
# Shadow RAM and SMRAM Routing Decoder

This block sits in a host bridge and decides, for every CPU memory address, whether a read is served by internal DRAM or by the external bus (ROM, ISA or PCI), and likewise for a write. The decision covers the legacy upper-memory area: a 32 KB video BIOS window, six 16 KB option-ROM windows, two 64 KB system BIOS halves, and the 128 KB SMRAM window together with a high alias of it. Any address outside these windows is ordinary DRAM.

Software programs the routing through a byte-wide configuration file with a synchronous write port and a combinational read port. After each accepted write, the decoder evaluates the nine shadow regions once. It latches their new attributes and raises a one-cycle flush pulse if at least one of them changed. It raises a separate one-cycle invalidate pulse when the upper BIOS half stops reading from DRAM, so that cached copies of it can be dropped. An accepted write moves the tracker from `ST_IDLE` to `ST_EVAL`. `ST_EVAL` stays in `ST_EVAL` on a further accepted write and returns to `ST_IDLE` otherwise. Routing always uses the latched attributes.

Top module: `shadow_smram_decoder`

## Requirements
- R1: After reset, configuration byte 0x00 reads 0x60, byte 0x01 reads 0x10, byte 0x60 reads 0x80, and every other byte reads 0x00. All nine shadow regions then read external and write internal.
- R2: A configuration read with a nonzero function number returns 0xFF. A write with a nonzero function number is ignored. Bytes 0x00 and 0x01 are read-only.
- R3: Region F0000–FFFFF takes its route from byte 0x55 bits [7:6] as follows: 00 reads external and writes internal; 01 reads and writes external; 10 reads and writes internal; 11 reads internal and writes external.
- R4: Region E0000–EFFFF uses the same four-entry table. Its index is byte 0x55 bits [7:6] with bit 7 forced to 0 unless the global shadow enable, byte 0x54 bit 0, is set.
- R5: Region C0000–C7FFF reads internal only when byte 0x54 bits 0 and 1 are both set. It writes internal when byte 0x55 bit 6 is 0 and external when that bit is 1.
- R6: Window i (i = 0..5) spans C8000 + i·16 KB for 16 KB. It reads internal only when byte 0x54 bit 0 and bit i+2 are both set. Its write route follows byte 0x55 bit 6 as in R5.
- R7: Addresses A0000–BFFFF read and write internal while the in-SMM input is high, or when byte 0x60 bit 0 is set. Otherwise they read and write external.
- R8: Addresses 0x0E0A0000–0x0E0BFFFF follow the R7 rules. When routed internal, the DRAM address output is 0x000A0000 plus the offset into the alias. When routed external, the DRAM address output equals the input address.
- R9: Every address outside the windows of R3–R8 reads and writes internal, and the DRAM address output equals the input address.
- R10: The latched routes update on the clock edge after an accepted write. The flush output is high for the following cycle only if at least one of the nine shadow regions changed. A write that changes no shadow region, including a write to byte 0x60, gives no flush pulse.
- R11: The invalidate output is high in the same cycle as the flush pulse exactly when region F0000–FFFFF changes from internal read to external read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_func | input | 3 | Configuration function number |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| mem_addr | input | 32 | CPU memory address to decode |
| in_smm | input | 1 | CPU is in system management mode |
| rd_internal | output | 1 | Read goes to internal DRAM (0: external bus) |
| wr_internal | output | 1 | Write goes to internal DRAM (0: external bus) |
| dram_addr | output | 32 | Address presented to DRAM after alias translation |
| flush_pulse | output | 1 | One-cycle pulse: a shadow region changed |
| inval_pulse | output | 1 | One-cycle pulse: upper BIOS half left internal read |

## Verification
The flush and invalidate pulses can coincide in one cycle, and the routing outputs change on the same edge that raises them. The bench provokes this by moving the upper BIOS half from table entry 11 to entry 01. It then samples both pulses and the new routes in the cycle after the evaluation edge. The bench also writes a value that changes a region's write route but not its read route, and writes the SMRAM control byte. These writes show that flush appears without invalidate and that a write changing no region leaves both pulses low.

// File: rtl/shd_pkg.sv
package shd_pkg;

    typedef struct packed {
        logic rd_int;
        logic wr_int;
    } route_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } trk_state_e;

    localparam logic [7:0] REG_SHADOW_EN = 8'h54;
    localparam logic [7:0] REG_BIOS_ATTR = 8'h55;
    localparam logic [7:0] REG_SMRAM_CTL = 8'h60;
    localparam logic [7:0] ID_LO_VAL     = 8'h60;
    localparam logic [7:0] ID_HI_VAL     = 8'h10;
    localparam logic [7:0] SMRAM_RST_VAL = 8'h80;

    // Four-entry BIOS attribute table: index bit 1 selects internal read,
    // index bit 0 selects external write.
    function automatic route_t bios_entry(input logic [1:0] idx);
        route_t r;
        r.rd_int = idx[1];
        r.wr_int = ~idx[0];
        return r;
    endfunction

endpackage

// File: rtl/shd_cfg_regs.sv
module shd_cfg_regs
    import shd_pkg::*;
#(
    parameter int AW = 8,
    parameter int FW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [FW-1:0] func,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    output logic          commit,
    output logic [7:0]    shadow_en,
    output logic [1:0]    bios_idx,
    output logic          smram_open
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] regs [DEPTH];

    assign commit = we && (func == '0) && (addr > AW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
            regs[0]                  <= ID_LO_VAL;
            regs[1]                  <= ID_HI_VAL;
            regs[AW'(REG_SMRAM_CTL)] <= SMRAM_RST_VAL;
        end else if (commit) begin
            regs[addr] <= wdata;
        end
    end

    assign rdata      = (func == '0) ? regs[addr] : 8'hFF;
    assign shadow_en  = regs[AW'(REG_SHADOW_EN)];
    assign bios_idx   = regs[AW'(REG_BIOS_ATTR)][7:6];
    assign smram_open = regs[AW'(REG_SMRAM_CTL)][0];

endmodule

// File: rtl/shd_attr_track.sv
module shd_attr_track
    import shd_pkg::*;
#(
    parameter int NUM_WIN = 6,
    localparam int NREG   = NUM_WIN + 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit,
    input  logic [NUM_WIN+1:0]    shadow_en,
    input  logic [1:0]            bios_idx,
    output route_t [NREG-1:0]     held,
    output logic                  flush,
    output logic                  inval
);
    localparam int IDX_VID = 0;
    localparam int IDX_LOW = NUM_WIN + 1;
    localparam int IDX_TOP = NUM_WIN + 2;

    trk_state_e        state_q, state_d;
    route_t [NREG-1:0] next_attr;
    logic              glob_en;

    assign glob_en = shadow_en[0];

    always_comb begin
        next_attr[IDX_VID].rd_int = glob_en & shadow_en[1];
        next_attr[IDX_VID].wr_int = ~bios_idx[0];
        next_attr[IDX_LOW]        = bios_entry({bios_idx[1] & glob_en, bios_idx[0]});
        next_attr[IDX_TOP]        = bios_entry(bios_idx);
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        assign next_attr[w+1].rd_int = glob_en & shadow_en[w+2];
        assign next_attr[w+1].wr_int = ~bios_idx[0];
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (commit) state_d = ST_EVAL;
            ST_EVAL: state_d = commit ? ST_EVAL : ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held  <= {NREG{2'b01}};
            flush <= 1'b0;
            inval <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    flush <= 1'b0;
                    inval <= 1'b0;
                end
                ST_EVAL: begin
                    held  <= next_attr;
                    flush <= (next_attr != held);
                    inval <= held[IDX_TOP].rd_int & ~next_attr[IDX_TOP].rd_int;
                end
            endcase
        end
    end

endmodule

// File: rtl/shd_addr_route.sv
module shd_addr_route
    import shd_pkg::*;
#(
    parameter int NUM_WIN = 6,
    localparam int NREG   = NUM_WIN + 3
) (
    input  logic [31:0]        addr,
    input  logic               in_smm,
    input  logic               smram_open,
    input  route_t [NREG-1:0]  held,
    output logic               rd_int,
    output logic               wr_int,
    output logic [31:0]        dram_addr
);
    localparam logic [14:0] SMRAM_TAG  = 15'h0005;
    localparam logic [14:0] ALIAS_TAG  = 15'h0705;
    localparam logic [5:0]  OPT_BLK0   = 6'h32;
    localparam logic [4:0]  VID_TAG    = 5'h18;
    localparam int          IDX_LOW    = NUM_WIN + 1;
    localparam int          IDX_TOP    = NUM_WIN + 2;

    logic       legacy, smram_hit, alias_hit, smram_ok;
    logic [5:0] blk, woff;
    route_t     r;

    assign legacy    = (addr[31:20] == 12'h000);
    assign smram_hit = (addr[31:17] == SMRAM_TAG);
    assign alias_hit = (addr[31:17] == ALIAS_TAG);
    assign smram_ok  = in_smm | smram_open;
    assign blk       = addr[19:14];
    assign woff      = blk - OPT_BLK0;

    always_comb begin
        r         = 2'b11;
        dram_addr = addr;
        if (smram_hit || alias_hit) begin
            r = smram_ok ? 2'b11 : 2'b00;
            if (alias_hit && smram_ok) dram_addr = {SMRAM_TAG, addr[16:0]};
        end else if (legacy) begin
            if (addr[19:16] == 4'hF)                 r = held[IDX_TOP];
            else if (addr[19:16] == 4'hE)            r = held[IDX_LOW];
            else if (addr[19:15] == VID_TAG)         r = held[0];
            else if (blk >= OPT_BLK0 && woff < 6'(NUM_WIN))
                r = held[woff + 6'd1];
        end
    end

    assign rd_int = r.rd_int;
    assign wr_int = r.wr_int;

endmodule

// File: rtl/shadow_smram_decoder.sv
module shadow_smram_decoder
    import shd_pkg::*;
#(
    parameter int NUM_WIN = 6,
    parameter int CFG_AW  = 8,
    parameter int CFG_FW  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_FW-1:0] cfg_func,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [31:0]       mem_addr,
    input  logic              in_smm,
    output logic              rd_internal,
    output logic              wr_internal,
    output logic [31:0]       dram_addr,
    output logic              flush_pulse,
    output logic              inval_pulse
);
    localparam int NREG = NUM_WIN + 3;

    logic              commit, smram_open;
    logic [7:0]        shadow_en;
    logic [1:0]        bios_idx;
    route_t [NREG-1:0] held;

    shd_cfg_regs #(.AW(CFG_AW), .FW(CFG_FW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .func       (cfg_func),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .rdata      (cfg_rdata),
        .commit     (commit),
        .shadow_en  (shadow_en),
        .bios_idx   (bios_idx),
        .smram_open (smram_open)
    );

    shd_attr_track #(.NUM_WIN(NUM_WIN)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .shadow_en (shadow_en[NUM_WIN+1:0]),
        .bios_idx  (bios_idx),
        .held      (held),
        .flush     (flush_pulse),
        .inval     (inval_pulse)
    );

    shd_addr_route #(.NUM_WIN(NUM_WIN)) u_route (
        .addr       (mem_addr),
        .in_smm     (in_smm),
        .smram_open (smram_open),
        .held       (held),
        .rd_int     (rd_internal),
        .wr_int     (wr_internal),
        .dram_addr  (dram_addr)
    );

endmodule

// File: rtl/shd_checker.sv
module shd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [31:0] mem_addr,
    input logic        in_smm,
    input logic        rd_internal,
    input logic        wr_internal,
    input logic [31:0] dram_addr,
    input logic        flush_pulse,
    input logic        inval_pulse
);
    a_r10_flush_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |-> $past(cfg_we, 2));

    a_r11_inval_with_flush: assert property (@(posedge clk) disable iff (!rst_n)
        inval_pulse |-> flush_pulse);

    a_r7_smm_owns_smram: assert property (@(posedge clk) disable iff (!rst_n)
        (in_smm && mem_addr[31:17] == 15'h0005) |-> (rd_internal && wr_internal));

    a_r8_alias_translate: assert property (@(posedge clk) disable iff (!rst_n)
        (in_smm && mem_addr[31:17] == 15'h0705) |-> (dram_addr == {15'h0005, mem_addr[16:0]}));

    a_r9_default_dram: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr[31:20] != 12'h000 && mem_addr[31:17] != 15'h0705)
            |-> (rd_internal && wr_internal && dram_addr == mem_addr));
endmodule

bind shadow_smram_decoder shd_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .mem_addr    (mem_addr),
    .in_smm      (in_smm),
    .rd_internal (rd_internal),
    .wr_internal (wr_internal),
    .dram_addr   (dram_addr),
    .flush_pulse (flush_pulse),
    .inval_pulse (inval_pulse)
);

// File: tb/shadow_smram_decoder_tb.sv
module shadow_smram_decoder_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_func = '0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [31:0] mem_addr = '0;
    logic        in_smm = 1'b0;
    logic        rd_internal, wr_internal, flush_pulse, inval_pulse;
    logic [31:0] dram_addr;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        int          kind;   // 0 route, 1 pulses, 2 config read
        logic [31:0] exp_val;
        logic        exp_a;
        logic        exp_b;
        string       tag;
    } item_t;

    item_t q[$];
    event  chk_ev;

    shadow_smram_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_func(cfg_func),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_addr(mem_addr), .in_smm(in_smm), .rd_internal(rd_internal),
        .wr_internal(wr_internal), .dram_addr(dram_addr),
        .flush_pulse(flush_pulse), .inval_pulse(inval_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_checks++;
                case (it.kind)
                    0: if (rd_internal !== it.exp_a || wr_internal !== it.exp_b || dram_addr !== it.exp_val) begin
                        n_fail++;
                        $display("FAIL %s route: actual rd=%b wr=%b dram=%h expected rd=%b wr=%b dram=%h",
                                 it.tag, rd_internal, wr_internal, dram_addr, it.exp_a, it.exp_b, it.exp_val);
                    end
                    1: if (flush_pulse !== it.exp_a || inval_pulse !== it.exp_b) begin
                        n_fail++;
                        $display("FAIL %s pulses: actual flush=%b inval=%b expected flush=%b inval=%b",
                                 it.tag, flush_pulse, inval_pulse, it.exp_a, it.exp_b);
                    end
                    default: if (cfg_rdata !== it.exp_val[7:0]) begin
                        n_fail++;
                        $display("FAIL %s cfg read: actual %h expected %h", it.tag, cfg_rdata, it.exp_val[7:0]);
                    end
                endcase
            end
        end
    end

    task automatic push(input int k, input logic [31:0] v, input logic a, input logic b, input string t);
        item_t it;
        it.kind = k; it.exp_val = v; it.exp_a = a; it.exp_b = b; it.tag = t;
        q.push_back(it);
        -> chk_ev;
        #2;
    endtask

    task automatic cfg_write(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_func = f; cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; cfg_func = '0;
    endtask

    // write, then observe the pulse cycle after the evaluation edge
    task automatic write_expect(input logic [7:0] a, input logic [7:0] d,
                                input logic fl, input logic inv, input string t);
        cfg_write(3'd0, a, d);
        @(negedge clk);
        push(1, '0, fl, inv, t);
    endtask

    task automatic route(input logic [31:0] ad, input logic smm, input logic rd, input logic wr,
                         input logic [31:0] da, input string t);
        mem_addr = ad; in_smm = smm;
        push(0, da, rd, wr, t);
    endtask

    task automatic cfg_read(input logic [2:0] f, input logic [7:0] a, input logic [7:0] e, input string t);
        cfg_func = f; cfg_addr = a;
        push(2, {24'h0, e}, 1'b0, 1'b0, t);
        cfg_func = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++; n_fail++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        cfg_read(3'd0, 8'h00, 8'h60, "R1");
        cfg_read(3'd0, 8'h01, 8'h10, "R1");
        cfg_read(3'd0, 8'h60, 8'h80, "R1");
        cfg_read(3'd0, 8'h54, 8'h00, "R1");
        route(32'h000F1234, 1'b0, 1'b0, 1'b1, 32'h000F1234, "R1");
        route(32'h000C4000, 1'b0, 1'b0, 1'b1, 32'h000C4000, "R1");
        route(32'h00100000, 1'b0, 1'b1, 1'b1, 32'h00100000, "R9");

        // R3 entry 10, R4 masked index
        write_expect(8'h55, 8'h80, 1'b1, 1'b0, "R10");
        route(32'h000F8000, 1'b0, 1'b1, 1'b1, 32'h000F8000, "R3");
        route(32'h000E0000, 1'b0, 1'b0, 1'b1, 32'h000E0000, "R4");

        // global enable unmasks low BIOS
        write_expect(8'h54, 8'h01, 1'b1, 1'b0, "R10");
        route(32'h000EFFFF, 1'b0, 1'b1, 1'b1, 32'h000EFFFF, "R4");
        route(32'h000C0000, 1'b0, 1'b0, 1'b1, 32'h000C0000, "R5");
        write_expect(8'h54, 8'h01, 1'b0, 1'b0, "R10 same value");

        // video and option windows
        write_expect(8'h54, 8'h87, 1'b1, 1'b0, "R10");
        route(32'h000C7FFF, 1'b0, 1'b1, 1'b1, 32'h000C7FFF, "R5");
        route(32'h000C8000, 1'b0, 1'b1, 1'b1, 32'h000C8000, "R6");
        route(32'h000CC000, 1'b0, 1'b0, 1'b1, 32'h000CC000, "R6");
        route(32'h000DFFFF, 1'b0, 1'b1, 1'b1, 32'h000DFFFF, "R6");

        // R3 entry 11: write route flips, no invalidate
        write_expect(8'h55, 8'hC0, 1'b1, 1'b0, "R11 no inval");
        route(32'h000F0000, 1'b0, 1'b1, 1'b0, 32'h000F0000, "R3");
        route(32'h000C0000, 1'b0, 1'b1, 1'b0, 32'h000C0000, "R5");
        route(32'h000C8000, 1'b0, 1'b1, 1'b0, 32'h000C8000, "R6");

        // R3 entry 01: internal->external read, flush and invalidate together
        write_expect(8'h55, 8'h40, 1'b1, 1'b1, "R11");
        route(32'h000F0000, 1'b0, 1'b0, 1'b0, 32'h000F0000, "R3");
        route(32'h000E0000, 1'b0, 1'b0, 1'b0, 32'h000E0000, "R4");
        write_expect(8'h55, 8'h40, 1'b0, 1'b0, "R11 repeat");

        // SMRAM and alias
        route(32'h000A0000, 1'b0, 1'b0, 1'b0, 32'h000A0000, "R7");
        route(32'h000B0000, 1'b1, 1'b1, 1'b1, 32'h000B0000, "R7");
        route(32'h0E0A1234, 1'b1, 1'b1, 1'b1, 32'h000A1234, "R8");
        route(32'h0E0A1234, 1'b0, 1'b0, 1'b0, 32'h0E0A1234, "R8");
        write_expect(8'h60, 8'h81, 1'b0, 1'b0, "R10 smram ctl");
        route(32'h000BFFFF, 1'b0, 1'b1, 1'b1, 32'h000BFFFF, "R7");
        route(32'h0E0BFFFF, 1'b0, 1'b1, 1'b1, 32'h000BFFFF, "R8");
        route(32'h0E0C0000, 1'b0, 1'b1, 1'b1, 32'h0E0C0000, "R9");

        // R2 function gating and read-only ID
        cfg_read(3'd2, 8'h55, 8'hFF, "R2");
        cfg_write(3'd1, 8'h55, 8'h80);
        @(negedge clk);
        push(1, '0, 1'b0, 1'b0, "R2");
        cfg_read(3'd0, 8'h55, 8'h40, "R2");
        route(32'h000F0000, 1'b0, 1'b0, 1'b0, 32'h000F0000, "R2");
        cfg_write(3'd0, 8'h00, 8'h12);
        cfg_read(3'd0, 8'h00, 8'h60, "R2");

        // R5 without global enable, R4 masking bit 7
        write_expect(8'h54, 8'h02, 1'b1, 1'b0, "R10");
        route(32'h000C0000, 1'b0, 1'b0, 1'b0, 32'h000C0000, "R5");
        write_expect(8'h55, 8'h80, 1'b1, 1'b0, "R10");
        route(32'h000E8000, 1'b0, 1'b0, 1'b1, 32'h000E8000, "R4");
        route(32'h000F8000, 1'b0, 1'b1, 1'b1, 32'h000F8000, "R3");

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule